// File: doc/BRIEF.md
# MAC Forwarding Lookup with Pause Handshake

This block resolves the output interfaces for a frame from its 48-bit destination MAC address. It holds a parameterized table of forwarding rules. Each rule has a 48-bit key, an output-interface bitmap with one bit per interface, and an enable bit. A lookup goes through a two-stage pipeline. The first stage compares the address against every rule at once and registers the match vector. The second stage picks the winning rule and registers the bitmap together with a hit flag. When no enabled rule matches, the result is a programmable fallback bitmap. An enabled rule with an all-zero bitmap is how a frame is dropped.

Software reaches the table, the fallback bitmap, a control word and a read-only information word through a simple word-addressed write/read port. Before editing the table, software sets a pause request. From then on the block refuses new lookups and lets the ones already in the pipeline finish. It then raises a pause-done status, which tells software that no lookup can see a half-written rule. Clearing the request resumes forwarding.

Top module: `mac_fwd_lookup`

## Requirements
- R1: After reset the control word reads 0, the fallback bitmap reads 0, pause_done is 0, lk_ready is 1, and every table rule is disabled. A lookup therefore returns res_hit=0 and a zero bitmap.
- R2: A lookup is accepted on a rising edge where lk_valid and lk_ready are both 1. Its result is presented with res_valid=1 for one cycle, starting at the second rising edge after acceptance. A lookup can be accepted every cycle. When the address equals the key of an enabled rule, the result has res_hit=1 and carries that rule's bitmap.
- R3: A rule whose enable bit is 0 keeps its stored contents but never matches a lookup.
- R4: When no enabled rule matches, the result has res_hit=0 and carries the fallback bitmap.
- R5: An enabled rule that matches and holds an all-zero bitmap yields res_hit=1 with a zero bitmap, which means drop.
- R6: When several enabled rules match, the rule with the lowest index supplies the bitmap.
- R7: The software port uses word addresses. Table rule i occupies addresses 4+4*i to 4+4*i+3, holding in order: key bits [31:0]; key bits [47:32] in data bits [15:0]; the bitmap in data bits [N-1:0]; and the enable in data bit 0. Read data appears on sw_rdata one cycle after sw_rd. In every bitmap, bit N-1 selects the first interface and bit 0 the last.
- R8: The information word at address 0 reads the interface count in bits [21:16] and the table depth in bits [15:0]. Writes to it have no effect.
- R9: The control word at address 1 holds the operating mode in bit 0 (1 = managed) and the pause request in bit 7, both writable. Bit 15 reads pause_done, and writes to bit 15 have no effect. The fallback bitmap is at address 2.
- R10: While the pause request is 1, lk_ready is 0 and no lookup is accepted. Lookups already in flight still complete. pause_done rises on the first edge at which the request is set and both pipeline stages are empty. While pause_done is 1, no result is presented.
- R11: pause_done returns to 0 one cycle after the request is cleared, and lookups are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_mac | input | 48 | Destination MAC address to resolve |
| lk_ready | output | 1 | Lookup can be accepted (low while pause is requested) |
| res_valid | output | 1 | Lookup result present this cycle |
| res_hit | output | 1 | An enabled rule matched |
| res_bitmap | output | NUM_IF | Output-interface selection for the frame |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_addr | input | ADDR_W | Word address |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, registered |
| pause_done | output | 1 | Pipeline drained under pause request |

## Verification
The bench aims at the pause drain while a lookup is accepted on the same edge that sets the request. A design that raised pause_done early would flag a safe state while a result is still pending, and one that blocked the in-flight lookup would lose a frame. Several rules share one key so that the priority can be checked: a highest-index-wins select returns the wrong bitmap. Two more cases are a disabled rule with a matching key, which a design that ignores the enable would forward, and an enabled empty-bitmap rule, which a design treating zero as "no match" would send to the fallback. Back-to-back lookups and the upper key word masking round out the address and pipeline cases.

// File: rtl/mac_fwd_pkg.sv
// Shared constants for the MAC forwarding lookup: software word map,
// control bit positions and the address width derivation.
package mac_fwd_pkg;
    localparam int unsigned OFS_INFO  = 0;
    localparam int unsigned OFS_CTRL  = 1;
    localparam int unsigned OFS_DFLT  = 2;
    localparam int unsigned TBL_BASE  = 4;
    localparam int unsigned FLD_KLO   = 0;
    localparam int unsigned FLD_KHI   = 1;
    localparam int unsigned FLD_BMP   = 2;
    localparam int unsigned FLD_EN    = 3;
    localparam int unsigned MODE_BIT  = 0;
    localparam int unsigned PREQ_BIT  = 7;
    localparam int unsigned PDONE_BIT = 15;
    localparam int unsigned KEY_W     = 48;

    // Word address width needed to cover the fixed words and the table.
    function automatic int unsigned addr_width(input int unsigned depth);
        return $clog2(TBL_BASE + 4 * depth);
    endfunction
endpackage

// File: rtl/mac_fwd_regs.sv
// Software-visible storage: control word, fallback bitmap and rule table.
// Assumes single-cycle writes and a registered read; at most one of
// sw_wr/sw_rd is used per cycle by the caller.
module mac_fwd_regs
    import mac_fwd_pkg::*;
#(
    parameter int unsigned NUM_IF = 8,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sw_wr,
    input  logic                          sw_rd,
    input  logic [ADDR_W-1:0]             sw_addr,
    input  logic [31:0]                   sw_wdata,
    output logic [31:0]                   sw_rdata,
    input  logic                          pause_done,
    output logic                          pause_req,
    output logic [DEPTH-1:0][KEY_W-1:0]   keys,
    output logic [DEPTH-1:0][NUM_IF-1:0]  bmps,
    output logic [DEPTH-1:0]              ens,
    output logic [NUM_IF-1:0]             dflt
);
    localparam int unsigned ENT_W = ADDR_W - 2;

    logic              mode_q;
    logic [ADDR_W-1:0] rel;
    logic [ENT_W-1:0]  ent;
    logic [1:0]        fld;
    logic              in_tbl;
    logic [31:0]       rd_mux;

    // Split the address into rule index and field inside the table window.
    always_comb begin
        rel    = sw_addr - ADDR_W'(TBL_BASE);
        ent    = rel[ADDR_W-1:2];
        fld    = rel[1:0];
        in_tbl = (sw_addr >= ADDR_W'(TBL_BASE)) && (ent < ENT_W'(DEPTH));
    end

    // Apply software writes to the control word, fallback and rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            pause_req <= 1'b0;
            dflt      <= '0;
            keys      <= '0;
            bmps      <= '0;
            ens       <= '0;
        end else if (sw_wr) begin
            if (sw_addr == ADDR_W'(OFS_CTRL)) begin
                mode_q    <= sw_wdata[MODE_BIT];
                pause_req <= sw_wdata[PREQ_BIT];
            end
            if (sw_addr == ADDR_W'(OFS_DFLT))
                dflt <= sw_wdata[NUM_IF-1:0];
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (in_tbl && ent == ENT_W'(i)) begin
                    if (fld == 2'(FLD_KLO)) keys[i][31:0]  <= sw_wdata;
                    if (fld == 2'(FLD_KHI)) keys[i][47:32] <= sw_wdata[15:0];
                    if (fld == 2'(FLD_BMP)) bmps[i]        <= sw_wdata[NUM_IF-1:0];
                    if (fld == 2'(FLD_EN))  ens[i]         <= sw_wdata[0];
                end
            end
        end
    end

    // Select the word addressed for a read.
    always_comb begin
        rd_mux = '0;
        if (sw_addr == ADDR_W'(OFS_INFO)) begin
            rd_mux[21:16] = 6'(NUM_IF);
            rd_mux[15:0]  = 16'(DEPTH);
        end
        if (sw_addr == ADDR_W'(OFS_CTRL)) begin
            rd_mux[MODE_BIT]  = mode_q;
            rd_mux[PREQ_BIT]  = pause_req;
            rd_mux[PDONE_BIT] = pause_done;
        end
        if (sw_addr == ADDR_W'(OFS_DFLT))
            rd_mux[NUM_IF-1:0] = dflt;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (in_tbl && ent == ENT_W'(i)) begin
                if (fld == 2'(FLD_KLO)) rd_mux[31:0]       = keys[i][31:0];
                if (fld == 2'(FLD_KHI)) rd_mux[15:0]       = keys[i][47:32];
                if (fld == 2'(FLD_BMP)) rd_mux[NUM_IF-1:0] = bmps[i];
                if (fld == 2'(FLD_EN))  rd_mux[0]          = ens[i];
            end
        end
    end

    // Register read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     sw_rdata <= '0;
        else if (sw_rd) sw_rdata <= rd_mux;
    end
endmodule

// File: rtl/mac_fwd_match.sv
// Stage 1: compare the presented address against every rule in parallel
// and register the enabled-match vector. Assumes lk_fire already includes
// the pause gating.
module mac_fwd_match
    import mac_fwd_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lk_fire,
    input  logic [KEY_W-1:0]            lk_mac,
    input  logic [DEPTH-1:0][KEY_W-1:0] keys,
    input  logic [DEPTH-1:0]            ens,
    output logic                        s1_v,
    output logic [DEPTH-1:0]            s1_hits
);
    logic [DEPTH-1:0] hits_c;

    // One comparator per rule, gated by its enable.
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
        assign hits_c[g] = ens[g] && (keys[g] == lk_mac);
    end

    // Capture the match vector of an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_hits <= '0;
        end else begin
            s1_v <= lk_fire;
            if (lk_fire) s1_hits <= hits_c;
        end
    end
endmodule

// File: rtl/mac_fwd_select.sv
// Stage 2: pick the lowest-indexed matching rule, or the fallback bitmap
// when nothing matched, and register the result.
module mac_fwd_select #(
    parameter int unsigned NUM_IF = 8,
    parameter int unsigned DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s1_v,
    input  logic [DEPTH-1:0]             s1_hits,
    input  logic [DEPTH-1:0][NUM_IF-1:0] bmps,
    input  logic [NUM_IF-1:0]            dflt,
    output logic                         res_valid,
    output logic                         res_hit,
    output logic [NUM_IF-1:0]            res_bitmap
);
    logic [NUM_IF-1:0] sel;

    // Priority select: scanning downward leaves the lowest index in sel.
    always_comb begin
        sel = dflt;
        for (int i = int'(DEPTH) - 1; i >= 0; i--)
            if (s1_hits[i]) sel = bmps[i];
    end

    // Register the result of a valid stage-1 entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_bitmap <= '0;
        end else begin
            res_valid <= s1_v;
            if (s1_v) begin
                res_hit    <= |s1_hits;
                res_bitmap <= sel;
            end
        end
    end
endmodule

// File: rtl/mac_fwd_pause.sv
// Pause handshake: blocks new lookups while a pause is requested and
// reports done once both pipeline stages are empty.
module mac_fwd_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_req,
    input  logic s1_v,
    input  logic res_valid,
    output logic lk_ready,
    output logic pause_done
);
    // Acceptance is refused for as long as the request stands.
    assign lk_ready = ~pause_req;

    // Done follows the request once the pipeline holds nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) pause_done <= 1'b0;
        else        pause_done <= pause_req & ~s1_v & ~res_valid;
    end
endmodule

// File: rtl/mac_fwd_lookup.sv
// Top: MAC forwarding lookup with a two-stage pipeline, software table
// port and pause handshake. Assumes NUM_IF <= 32 and DEPTH < 65536.
module mac_fwd_lookup
    import mac_fwd_pkg::*;
#(
    parameter int unsigned NUM_IF = 8,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned ADDR_W = addr_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [47:0]       lk_mac,
    output logic              lk_ready,
    output logic              res_valid,
    output logic              res_hit,
    output logic [NUM_IF-1:0] res_bitmap,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    output logic              pause_done
);
    logic                         pause_req;
    logic [DEPTH-1:0][KEY_W-1:0]  keys;
    logic [DEPTH-1:0][NUM_IF-1:0] bmps;
    logic [DEPTH-1:0]             ens;
    logic [NUM_IF-1:0]            dflt;
    logic                         s1_v;
    logic [DEPTH-1:0]             s1_hits;
    logic                         lk_fire;

    assign lk_fire = lk_valid & lk_ready;

    mac_fwd_regs #(.NUM_IF(NUM_IF), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .pause_done(pause_done), .pause_req(pause_req),
        .keys(keys), .bmps(bmps), .ens(ens), .dflt(dflt)
    );

    mac_fwd_match #(.DEPTH(DEPTH)) u_match (
        .clk(clk), .rst_n(rst_n), .lk_fire(lk_fire), .lk_mac(lk_mac),
        .keys(keys), .ens(ens), .s1_v(s1_v), .s1_hits(s1_hits)
    );

    mac_fwd_select #(.NUM_IF(NUM_IF), .DEPTH(DEPTH)) u_select (
        .clk(clk), .rst_n(rst_n), .s1_v(s1_v), .s1_hits(s1_hits),
        .bmps(bmps), .dflt(dflt), .res_valid(res_valid),
        .res_hit(res_hit), .res_bitmap(res_bitmap)
    );

    mac_fwd_pause u_pause (
        .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .s1_v(s1_v),
        .res_valid(res_valid), .lk_ready(lk_ready), .pause_done(pause_done)
    );
endmodule

// File: rtl/mac_fwd_lookup_chk.sv
// Property checker for the lookup pipeline and pause handshake, bound
// into every instance of the top module.
module mac_fwd_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic lk_ready,
    input logic pause_req,
    input logic pause_done,
    input logic s1_v,
    input logic res_valid
);
    // R10: done implies both stages are empty
    a_r10_drained: assert property (@(posedge clk) disable iff (!rst_n)
        pause_done |-> (!s1_v && !res_valid));

    // R10: done is only raised for a standing request
    a_r10_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_done) |-> $past(pause_req));

    // R11: done drops the cycle after the request is cleared
    a_r11_done_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pause_req) |=> !pause_done);

    // R2: every result comes from a lookup accepted two edges earlier
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lk_valid && lk_ready, 2));
endmodule

bind mac_fwd_lookup mac_fwd_lookup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .pause_req(pause_req), .pause_done(pause_done), .s1_v(s1_v),
    .res_valid(res_valid)
);

// File: tb/mac_fwd_lookup_bench.sv
// Directed bench for mac_fwd_lookup: one task per scenario.
module mac_fwd_lookup_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NIF = 8;
    localparam int DEP = 8;
    localparam int AW  = mac_fwd_pkg::addr_width(DEP);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           lk_valid = 1'b0;
    logic [47:0]    lk_mac = '0;
    logic           lk_ready;
    logic           res_valid;
    logic           res_hit;
    logic [NIF-1:0] res_bitmap;
    logic           sw_wr = 1'b0;
    logic           sw_rd = 1'b0;
    logic [AW-1:0]  sw_addr = '0;
    logic [31:0]    sw_wdata = '0;
    logic [31:0]    sw_rdata;
    logic           pause_done;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [47:0] MAC_A = 48'h02AA_BB00_0001;
    localparam logic [47:0] MAC_B = 48'h02AA_BB00_0002;
    localparam logic [47:0] MAC_C = 48'h02AA_BB00_0003;
    localparam logic [47:0] MAC_D = 48'h02AA_BB00_0004;
    localparam logic [47:0] MAC_E = 48'h03CC_0000_0077;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_fwd_lookup #(.NUM_IF(NIF), .DEPTH(DEP)) u_mac_fwd_lookup (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_mac(lk_mac),
        .lk_ready(lk_ready), .res_valid(res_valid), .res_hit(res_hit),
        .res_bitmap(res_bitmap), .sw_wr(sw_wr), .sw_rd(sw_rd),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .pause_done(pause_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ent_addr(input int i, input int f);
        return AW'(4 + 4 * i + f);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); sw_rd = 1'b1; sw_addr = a;
        @(negedge clk); sw_rd = 1'b0; d = sw_rdata;
    endtask

    task automatic put_rule(input int i, input logic [47:0] k, input logic [7:0] b, input bit en);
        wr(ent_addr(i, 0), k[31:0]);
        wr(ent_addr(i, 1), {16'h0, k[47:32]});
        wr(ent_addr(i, 2), {24'h0, b});
        wr(ent_addr(i, 3), {31'h0, en});
    endtask

    task automatic look(input logic [47:0] mac, input bit eh, input logic [7:0] eb, input string tag);
        @(negedge clk); lk_valid = 1'b1; lk_mac = mac;
        @(negedge clk); lk_valid = 1'b0;
        chk({tag, " no early result"}, 32'(res_valid), 32'd0);
        @(negedge clk);
        chk({tag, " valid"}, 32'(res_valid), 32'd1);
        chk({tag, " hit"},   32'(res_hit),   32'(eh));
        chk({tag, " bitmap"}, 32'(res_bitmap), 32'(eb));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pause_done", 32'(pause_done), 32'd0);
        chk("R1 lk_ready", 32'(lk_ready), 32'd1);
        rd(AW'(1), d); chk("R1 control", d, 32'h0);
        rd(AW'(2), d); chk("R1 fallback", d, 32'h0);
        look(MAC_A, 1'b0, 8'h00, "R1 empty table");
    endtask

    task automatic t_info();
        logic [31:0] d;
        rd(AW'(0), d); chk("R8 info", d, 32'h0008_0008);
        wr(AW'(0), 32'hFFFF_FFFF);
        rd(AW'(0), d); chk("R8 info write ignored", d, 32'h0008_0008);
    endtask

    task automatic t_table_rw();
        logic [31:0] d;
        wr(ent_addr(3, 0), 32'hDEAD_BEEF);
        wr(ent_addr(3, 1), 32'hABCD_1234);
        wr(ent_addr(3, 2), 32'hFFFF_FF5A);
        wr(ent_addr(3, 3), 32'h0000_0000);
        rd(ent_addr(3, 0), d); chk("R7 key low", d, 32'hDEAD_BEEF);
        rd(ent_addr(3, 1), d); chk("R7 key high 16 bits", d, 32'h0000_1234);
        rd(ent_addr(3, 2), d); chk("R7 bitmap width", d, 32'h0000_005A);
        rd(ent_addr(3, 3), d); chk("R7 enable", d, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(AW'(1), 32'h0000_8001);
        rd(AW'(1), d); chk("R9 mode set, bit15 read-only", d, 32'h0000_0001);
        chk("R9 no pause from bit15 write", 32'(pause_done), 32'd0);
        wr(AW'(1), 32'h0);
        wr(AW'(2), 32'h0000_0001);
        rd(AW'(2), d); chk("R9 fallback readback", d, 32'h1);
    endtask

    task automatic t_lookups();
        put_rule(0, MAC_A, 8'h80, 1'b1);
        look(MAC_A, 1'b1, 8'h80, "R2 match first iface");
        put_rule(1, MAC_B, 8'h11, 1'b0);
        look(MAC_B, 1'b0, 8'h01, "R3 disabled rule");
        look(MAC_C, 1'b0, 8'h01, "R4 unknown to fallback");
        put_rule(2, MAC_D, 8'h00, 1'b1);
        look(MAC_D, 1'b1, 8'h00, "R5 drop rule");
        put_rule(4, MAC_E, 8'h0F, 1'b1);
        put_rule(5, MAC_E, 8'hF0, 1'b1);
        look(MAC_E, 1'b1, 8'h0F, "R6 lowest index wins");
        wr(ent_addr(4, 3), 32'h0);
        look(MAC_E, 1'b1, 8'hF0, "R6 next rule after disable");
    endtask

    task automatic t_back_to_back();
        @(negedge clk); lk_valid = 1'b1; lk_mac = MAC_A;
        @(negedge clk); lk_mac = MAC_D;
        @(negedge clk); lk_mac = MAC_C;
        chk("R2 b2b first", {res_valid, res_hit, 22'h0, res_bitmap}, {2'b11, 22'h0, 8'h80});
        @(negedge clk); lk_valid = 1'b0;
        chk("R2 b2b second", {res_valid, res_hit, 22'h0, res_bitmap}, {2'b11, 22'h0, 8'h00});
        @(negedge clk);
        chk("R2 b2b third", {res_valid, res_hit, 22'h0, res_bitmap}, {2'b10, 22'h0, 8'h01});
        @(negedge clk);
        chk("R2 b2b ends", 32'(res_valid), 32'd0);
    endtask

    task automatic t_pause_idle();
        wr(AW'(1), 32'h80);
        chk("R10 idle done not yet", 32'(pause_done), 32'd0);
        chk("R10 ready low", 32'(lk_ready), 32'd0);
        @(negedge clk);
        chk("R10 idle done", 32'(pause_done), 32'd1);
        wr(AW'(1), 32'h0);
        @(negedge clk);
        chk("R11 done falls", 32'(pause_done), 32'd0);
        chk("R11 ready back", 32'(lk_ready), 32'd1);
    endtask

    task automatic t_pause_inflight();
        logic [31:0] d;
        @(negedge clk);
        lk_valid = 1'b1; lk_mac = MAC_A;
        sw_wr = 1'b1; sw_addr = AW'(1); sw_wdata = 32'h80;
        @(negedge clk); sw_wr = 1'b0;
        chk("R10 ready low after request", 32'(lk_ready), 32'd0);
        chk("R10 not done, stage1 busy", 32'(pause_done), 32'd0);
        @(negedge clk);
        chk("R10 in-flight completes", {res_valid, 23'h0, res_bitmap}, {1'b1, 23'h0, 8'h80});
        chk("R10 not done, stage2 busy", 32'(pause_done), 32'd0);
        @(negedge clk);
        chk("R10 no second result", 32'(res_valid), 32'd0);
        chk("R10 still draining", 32'(pause_done), 32'd0);
        @(negedge clk);
        chk("R10 done after drain", 32'(pause_done), 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 held lookup refused", 32'(res_valid), 32'd0);
        end
        lk_valid = 1'b0;
        rd(AW'(1), d); chk("R9 control shows done", d, 32'h0000_8080);
        wr(AW'(1), 32'h0);
        @(negedge clk);
        chk("R11 done falls", 32'(pause_done), 32'd0);
        look(MAC_A, 1'b1, 8'h80, "R11 forwarding resumes");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_info();
        t_table_rw();
        t_ctrl();
        t_lookups();
        t_back_to_back();
        t_pause_idle();
        t_pause_inflight();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule